// File: doc/BRIEF.md
# Over-Current Fault Timer and Restart Sequencer

This block is the digital fault handler of a peak-current-mode switching converter. It watches a per-cycle over-current comparator. While that comparator reports an excess, it counts millisecond ticks. If the excess lasts long enough, it stops the gate drive and drops the controller into a low-consumption state. The count is forgiven only after an unbroken run of clean switching pulses.

Once a fault is validated, the block sequences the supply rail. It leaves the start-up current source off while the rail decays. It turns the source on when the rail reaches its minimum level and turns it off again at the turn-on level. Two restart policies are selected by a strap. In auto-recovery mode, a long recovery timer must finish before a turn-on crossing may restart the converter. In latch-off mode, the rail cycles up and down without end until a supply reset or a brown-out event clears the latch.

Every start asks the soft-start generator for a ramp lasting a fixed number of milliseconds. All time constants are parameters, so scaled values can be used.

Top module: `ocp_restart_ctrl`

## Requirements
- R1: After reset the block is in the charge state: hv_en=1, drv_en=0, low_pwr=0, ss_req=0.
- R2: In the charge state, vcc_on high on a clock edge sets drv_en=1 and hv_en=0 from that edge on.
- R3: ss_req rises together with drv_en at every start and falls on the edge of the SS_MS-th ms_tick counted after the start.
- R4: The fault count advances only on ms_tick cycles with oc_flag high. On the FAULT_MS-th such tick, drv_en falls and low_pwr rises on the same edge.
- R5: A run of CLEAN_PULSES consecutive pulse_end strobes with oc_flag low clears the fault count. A pulse_end with oc_flag high restarts that run from zero.
- R6: After a validated fault, hv_en stays low until vcc_min is seen. It then stays high until vcc_on is seen, while low_pwr stays high throughout.
- R7: In auto-recovery mode (latch_mode=0), a vcc_on crossing before the recovery timer has finished turns hv_en off and leaves drv_en off.
- R8: In auto-recovery mode, once RECOVER_MS ms_ticks have been counted since fault validation, the next vcc_on crossing during charging restarts drive with soft-start.
- R9: In latch-off mode (latch_mode=1), a faulted block never re-enables drv_en, whatever the ticks. The rail keeps cycling between vcc_min and vcc_on.
- R10: vcc_rst or brown_out high on an edge returns the block to the charge state of R1 from any state and clears all timers. These two inputs take priority over every other input.
- R11: drv_en is never high together with hv_en or with low_pwr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe per elapsed millisecond |
| pulse_end | input | 1 | One-cycle strobe at each switching-pulse boundary |
| oc_flag | input | 1 | Current sense above the maximum setpoint |
| vcc_on | input | 1 | Supply above the turn-on level |
| vcc_min | input | 1 | Supply below the minimum level |
| vcc_rst | input | 1 | Supply below the reset level |
| brown_out | input | 1 | Line brown-out event |
| latch_mode | input | 1 | 1 = latch-off, 0 = auto-recovery |
| drv_en | output | 1 | Gate-drive enable |
| hv_en | output | 1 | Start-up current-source enable |
| low_pwr | output | 1 | Low-consumption fault state |
| ss_req | output | 1 | Soft-start request window |

## Verification
Every output is decoded from registers that update on the edge where the triggering strobe is seen. A stimulus driven after one falling edge therefore shows its result at the next falling edge, one cycle later, with no pipeline in between. The bench drives each strobe for exactly one cycle and compares all four outputs at that next falling edge. The boundary cases are checked one tick before and exactly at the limit: the FAULT_MS-th flagged tick, the SS_MS-th tick and the RECOVER_MS-th tick.

// File: rtl/ocp_restart_pkg.sv
package ocp_restart_pkg;
  typedef enum logic [1:0] {
    ST_CHARGE   = 2'd0,  // initial charge of the rail
    ST_RUN      = 2'd1,  // switching
    ST_DECAY    = 2'd2,  // faulted, source off, rail decaying
    ST_RECHARGE = 2'd3   // faulted, source on, rail charging
  } ocp_state_e;
endpackage

// File: rtl/ocp_fault_timer.sv
module ocp_fault_timer #(
  parameter int FAULT_MS     = 64,
  parameter int CLEAN_PULSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ms_tick,
  input  logic pulse_end,
  input  logic oc_flag,
  output logic expired
);
  localparam int FW = $clog2(FAULT_MS + 1);
  localparam int CW = $clog2(CLEAN_PULSES + 1);

  logic [FW-1:0] ft_q, ft_d;
  logic [CW-1:0] cl_q, cl_d;
  logic          clean_done;

  assign clean_done = pulse_end && !oc_flag && (cl_q == CW'(CLEAN_PULSES - 1));

  always_comb begin
    ft_d    = ft_q;
    cl_d    = cl_q;
    expired = 1'b0;
    if (!enable) begin
      ft_d = '0;
      cl_d = '0;
    end else begin
      if (pulse_end) begin
        if (oc_flag || clean_done) cl_d = '0;
        else                       cl_d = cl_q + 1'b1;
      end
      if (clean_done) begin
        ft_d = '0;
      end else if (ms_tick && oc_flag) begin
        if (ft_q == FW'(FAULT_MS - 1)) begin
          expired = 1'b1;
          ft_d    = '0;
        end else begin
          ft_d = ft_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_q <= '0;
      cl_q <= '0;
    end else begin
      ft_q <= ft_d;
      cl_q <= cl_d;
    end
  end
endmodule

// File: rtl/ocp_softstart.sv
module ocp_softstart #(
  parameter int SS_MS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  input  logic ms_tick,
  output logic active
);
  localparam int SW = $clog2(SS_MS + 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (clear) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q && ms_tick) begin
      if (cnt_q == SW'(SS_MS - 1)) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/ocp_restart_fsm.sv
module ocp_restart_fsm
  import ocp_restart_pkg::*;
#(
  parameter int RECOVER_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       expired,
  input  logic       vcc_on,
  input  logic       vcc_min,
  input  logic       vcc_rst,
  input  logic       brown_out,
  input  logic       latch_mode,
  output ocp_state_e state,
  output ocp_state_e state_next,
  output logic       start
);
  localparam int RW = $clog2(RECOVER_MS + 1);

  ocp_state_e    st_q, st_d;
  logic [RW-1:0] rc_q, rc_d;
  logic          rec_done;
  logic          faulted;

  assign rec_done = (rc_q == RW'(RECOVER_MS));
  assign faulted  = (st_q == ST_DECAY) || (st_q == ST_RECHARGE);

  always_comb begin
    st_d  = st_q;
    rc_d  = rc_q;
    start = 1'b0;
    if (faulted && ms_tick && !rec_done) rc_d = rc_q + 1'b1;
    if (vcc_rst || brown_out) begin
      st_d = ST_CHARGE;
      rc_d = '0;
    end else begin
      case (st_q)
        ST_CHARGE: if (vcc_on) begin
          st_d  = ST_RUN;
          start = 1'b1;
        end
        ST_RUN: if (expired) begin
          st_d = ST_DECAY;
          rc_d = '0;
        end
        ST_DECAY: if (vcc_min) st_d = ST_RECHARGE;
        ST_RECHARGE: if (vcc_on) begin
          if (!latch_mode && rec_done) begin
            st_d  = ST_RUN;
            start = 1'b1;
          end else begin
            st_d = ST_DECAY;
          end
        end
        default: st_d = ST_CHARGE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_CHARGE;
      rc_q <= '0;
    end else begin
      st_q <= st_d;
      rc_q <= rc_d;
    end
  end

  assign state      = st_q;
  assign state_next = st_d;
endmodule

// File: rtl/ocp_restart_ctrl.sv
module ocp_restart_ctrl
  import ocp_restart_pkg::*;
#(
  parameter int FAULT_MS     = 64,
  parameter int CLEAN_PULSES = 8,
  parameter int RECOVER_MS   = 1000,
  parameter int SS_MS        = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pulse_end,
  input  logic oc_flag,
  input  logic vcc_on,
  input  logic vcc_min,
  input  logic vcc_rst,
  input  logic brown_out,
  input  logic latch_mode,
  output logic drv_en,
  output logic hv_en,
  output logic low_pwr,
  output logic ss_req
);
  ocp_state_e state, state_next;
  logic       expired;
  logic       start;
  logic       running;

  assign running = (state == ST_RUN);

  ocp_fault_timer #(.FAULT_MS(FAULT_MS), .CLEAN_PULSES(CLEAN_PULSES)) u_ftmr (
    .clk(clk), .rst_n(rst_n), .enable(running), .ms_tick(ms_tick),
    .pulse_end(pulse_end), .oc_flag(oc_flag), .expired(expired)
  );

  ocp_restart_fsm #(.RECOVER_MS(RECOVER_MS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .expired(expired),
    .vcc_on(vcc_on), .vcc_min(vcc_min), .vcc_rst(vcc_rst),
    .brown_out(brown_out), .latch_mode(latch_mode),
    .state(state), .state_next(state_next), .start(start)
  );

  ocp_softstart #(.SS_MS(SS_MS)) u_ss (
    .clk(clk), .rst_n(rst_n), .start(start),
    .clear(state_next != ST_RUN), .ms_tick(ms_tick), .active(ss_req)
  );

  assign drv_en  = running;
  assign hv_en   = (state == ST_CHARGE) || (state == ST_RECHARGE);
  assign low_pwr = (state == ST_DECAY) || (state == ST_RECHARGE);
endmodule

// File: rtl/ocp_restart_ctrl_chk.sv
module ocp_restart_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic vcc_min,
  input logic vcc_rst,
  input logic brown_out,
  input logic latch_mode,
  input logic drv_en,
  input logic hv_en,
  input logic low_pwr,
  input logic ss_req
);
  // R11
  drv_hv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_en && hv_en));
  // R11
  drv_lowpwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_en && low_pwr));
  // R3
  ss_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> ss_req);
  // R6
  hv_after_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hv_en) && low_pwr) |-> $past(vcc_min));
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && latch_mode && !vcc_rst && !brown_out) |=> !drv_en);
  // R10
  supply_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_rst || brown_out) |=> (hv_en && !low_pwr && !drv_en));
  // R4
  stop_into_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drv_en) && !$past(vcc_rst) && !$past(brown_out)) |-> low_pwr);
endmodule

bind ocp_restart_ctrl ocp_restart_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_min(vcc_min), .vcc_rst(vcc_rst),
  .brown_out(brown_out), .latch_mode(latch_mode), .drv_en(drv_en),
  .hv_en(hv_en), .low_pwr(low_pwr), .ss_req(ss_req)
);

// File: tb/ocp_restart_ctrl_test.sv
module ocp_restart_ctrl_test;
  localparam int FAULT_MS = 6, CLEAN = 8, RECOVER_MS = 20, SS_MS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 0, pulse_end = 0, oc_flag = 0, vcc_on = 0, vcc_min = 0;
  logic vcc_rst = 0, brown_out = 0, latch_mode = 0;
  logic drv_en, hv_en, low_pwr, ss_req;
  int   n_chk = 0, n_fail = 0;
  int   mft = 0, mcl = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  ocp_restart_ctrl #(.FAULT_MS(FAULT_MS), .CLEAN_PULSES(CLEAN),
                     .RECOVER_MS(RECOVER_MS), .SS_MS(SS_MS)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pulse_end(pulse_end),
    .oc_flag(oc_flag), .vcc_on(vcc_on), .vcc_min(vcc_min), .vcc_rst(vcc_rst),
    .brown_out(brown_out), .latch_mode(latch_mode), .drv_en(drv_en),
    .hv_en(hv_en), .low_pwr(low_pwr), .ss_req(ss_req));

  // Expected {drv_en, hv_en, low_pwr, ss_req} for a named situation
  function automatic logic [3:0] pat(input bit d, input bit h, input bit l, input bit s);
    return {d, h, l, s};
  endfunction

  // Requirement model of the fault count; returns 1 when the fault is due
  // kind: 0 flagged tick, 1 clean pulse, 2 flagged pulse, 3 plain tick
  function automatic bit model_event(input int kind);
    bit f = 0;
    case (kind)
      0: begin mft++; if (mft == FAULT_MS) f = 1; end
      1: begin mcl++; if (mcl == CLEAN) begin mcl = 0; mft = 0; end end
      2: mcl = 0;
      default: ;
    endcase
    return f;
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act = {drv_en, hv_en, low_pwr, ss_req};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {drv,hv,low,ss} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ev(input bit tick, input bit pe, input bit oc);
    ms_tick = tick; pulse_end = pe; oc_flag = oc;
    @(negedge clk);
    ms_tick = 0; pulse_end = 0; oc_flag = 0;
  endtask

  task automatic strobe_on();  vcc_on = 1;    @(negedge clk); vcc_on = 0;    endtask
  task automatic strobe_min(); vcc_min = 1;   @(negedge clk); vcc_min = 0;   endtask
  task automatic strobe_rst(); vcc_rst = 1;   @(negedge clk); vcc_rst = 0;   endtask
  task automatic strobe_bo();  brown_out = 1; @(negedge clk); brown_out = 0; endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", pat(0,1,0,0));

    strobe_on();
    check("R2 start", pat(1,0,0,1));

    // R3 soft-start window
    ev(1,0,0); ev(1,0,0);
    check("R3 ss before limit", pat(1,0,0,1));
    ev(1,0,0);
    check("R3 ss after limit", pat(1,0,0,0));

    // R4 only flagged ticks count
    for (int i = 0; i < FAULT_MS-1; i++) ev(1,0,1);
    for (int i = 0; i < 10; i++) ev(1,0,0);
    check("R4 unflagged ticks ignored", pat(1,0,0,0));

    // R5 clean run clears the count
    for (int i = 0; i < CLEAN; i++) ev(0,1,0);
    for (int i = 0; i < FAULT_MS-1; i++) ev(1,0,1);
    check("R5 count cleared by clean run", pat(1,0,0,0));
    for (int i = 0; i < CLEAN-1; i++) ev(0,1,0);
    ev(0,1,1);
    for (int i = 0; i < CLEAN-1; i++) ev(0,1,0);
    check("R5 broken run keeps count", pat(1,0,0,0));
    ev(1,0,1);
    check("R4 fault at limit", pat(0,0,1,0));

    // R6 / R7 / R8 auto-recovery hiccup
    ev(0,0,0); ev(0,0,0);
    check("R6 source off while decaying", pat(0,0,1,0));
    strobe_min();
    check("R6 source on at minimum", pat(0,1,1,0));
    strobe_on();
    check("R7 early turn-on crossing", pat(0,0,1,0));
    for (int i = 0; i < RECOVER_MS-1; i++) ev(1,0,0);
    strobe_min(); strobe_on();
    check("R8 one tick short", pat(0,0,1,0));
    ev(1,0,0);
    strobe_min();
    check("R6 recharge", pat(0,1,1,0));
    strobe_on();
    check("R8 restart with soft-start", pat(1,0,0,1));

    // R9 latch-off
    latch_mode = 1;
    for (int i = 0; i < FAULT_MS; i++) ev(1,0,1);
    check("R9 latched fault", pat(0,0,1,0));
    for (int i = 0; i < RECOVER_MS+5; i++) ev(1,0,0);
    for (int k = 0; k < 3; k++) begin
      strobe_min();
      check("R9 hiccup charge", pat(0,1,1,0));
      strobe_on();
      check("R9 hiccup no restart", pat(0,0,1,0));
    end
    strobe_bo();
    check("R10 brown-out clears latch", pat(0,1,0,0));
    strobe_on();
    check("R2 start after brown-out", pat(1,0,0,1));
    strobe_rst();
    check("R10 supply reset from run", pat(0,1,0,0));
    latch_mode = 0;
    strobe_on();

    // Random fault-count traffic against the requirement model
    void'($urandom(32'h0000_5EED));
    mft = 0; mcl = 0;
    for (int n = 0; n < 600; n++) begin
      int  r = $urandom_range(0, 9);
      int  kind = (r < 3) ? 0 : (r < 7) ? 1 : (r < 8) ? 2 : 3;
      bit  f = model_event(kind);
      case (kind)
        0: ev(1,0,1);
        1: ev(0,1,0);
        2: ev(0,1,1);
        default: ev(1,0,0);
      endcase
      n_chk++;
      if (drv_en !== !f || (drv_en && (hv_en || low_pwr))) begin
        n_fail++;
        $display("FAIL R4/R5/R11 random: drv %b hv %b low %b expected drv %b",
                 drv_en, hv_en, low_pwr, !f);
      end
      if (f) begin
        strobe_rst();
        strobe_on();
        mft = 0; mcl = 0;
      end
    end

    finish_run();
  end
endmodule